// File: doc/BRIEF.md
# Level-Following Interrupt Controller

This block sits between up to 32 device interrupt lines and one processor core. It samples every line into a status register on each clock, so a status bit is a one-cycle-delayed copy of its line. The bit drops on its own once the device withdraws its request, and software never clears it. A software-written mask selects which sources may interrupt the core. A global enable flag gates the single exception request that goes to the core.

The block also holds the core's global enable flag. When the core takes the exception, the flag is cleared and its previous value is kept in a one-bit shadow. A return-from-exception pulse copies the shadow back into the flag, and software can also set or clear the flag through the register port. To defer one device, software masks it and then re-enables interrupts, so the other sources still get through. The register port is a single-cycle write strobe with an address, plus a combinational read path.

Top module: `lvl_irq_ctrl`

## Requirements
- R1: While reset is high, at the first clock edge the mask, the status, the global enable, the enable shadow and the exception request all become 0. This means every source is masked.
- R2: A status bit reads 1 after the first rising clock edge at which its device line is 1, and not before that edge.
- R3: A status bit reads 0 after the first rising clock edge at which its line is 0, with no software write.
- R4: Address 1 reads the status in bits [NUM_SRC-1:0]. A write to address 1 has no effect on any register.
- R5: A write to address 0 loads the mask from write-data bits [NUM_SRC-1:0], and address 0 reads the mask back. A mask bit of 0 stops its source from raising the exception request.
- R6: The exception request is a register. After each clock edge it equals the OR over all sources of (status AND mask), ANDed with the global enable, all taken as updated at that same edge.
- R7: An exception-entry pulse clears the global enable at the next edge and saves the enable value it had before that edge into the shadow.
- R8: A return pulse without an entry pulse loads the global enable from the shadow at the next edge.
- R9: A write to address 2 loads the global enable from write-data bit 0. Address 2 reads the enable in bit 0 and zeros in all other bits.
- R10: When events coincide in one cycle, exception entry wins over return, and return wins over a software write to address 2.
- R11: If a device holds its unmasked line high while the enable is off, the request asserts again on the edge that restores the enable.
- R12: Address 3 reads as 0, and writes to it change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| irq_lines | input | NUM_SRC | Level interrupt requests from the devices |
| exc_take | input | 1 | One-cycle pulse: the core enters the interrupt exception |
| exc_return | input | 1 | One-cycle pulse: the core returns from the exception |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address: 0 mask, 1 status, 2 enable, 3 unused |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Register read data for reg_addr (combinational) |
| exc_req | output | 1 | Registered interrupt-exception request to the core |

## Verification
The assertions take for granted that every input is synchronous to clk and settles before the rising edge. They also take for granted that exc_take and exc_return are single-cycle pulses, that the status check is skipped on the first cycle after reset, and that reg_addr is valid whenever reg_wr is high. The bench drives all inputs just after the falling edge and holds them for a whole cycle. It samples outputs and read data at the next falling edge. It raises take and return together, and return together with an enable write, only in the scenario that exercises priority.

// File: rtl/lvl_irq_pkg.sv
package lvl_irq_pkg;
   // Register addresses decoded by the read and write paths.
   typedef enum logic [1:0] {
      REG_MASK   = 2'd0,
      REG_STATUS = 2'd1,
      REG_ENABLE = 2'd2,
      REG_SPARE  = 2'd3
   } irq_reg_e;
endpackage

// File: rtl/irq_level_track.sv
module irq_level_track #(
   parameter int NUM_SRC = 32
) (
   input  logic               clk,
   input  logic               rst,
   input  logic [NUM_SRC-1:0] lines,
   output logic [NUM_SRC-1:0] status,
   output logic [NUM_SRC-1:0] status_nxt
);
   // One flop per source; each bit follows its line with one cycle of delay.
   for (genvar g = 0; g < NUM_SRC; g++) begin : g_bit
      assign status_nxt[g] = rst ? 1'b0 : lines[g];
      always_ff @(posedge clk) status[g] <= status_nxt[g];
   end

   // R2 R3
   status_follow_chk: assert property (@(posedge clk) disable iff (rst)
      !$past(rst) |-> status == $past(lines));
endmodule

// File: rtl/irq_mask_bank.sv
module irq_mask_bank #(
   parameter int NUM_SRC = 32
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               load,
   input  logic [NUM_SRC-1:0] load_val,
   output logic [NUM_SRC-1:0] mask,
   output logic [NUM_SRC-1:0] mask_nxt
);
   always_comb begin
      if (rst)       mask_nxt = '0;
      else if (load) mask_nxt = load_val;
      else           mask_nxt = mask;
   end

   always_ff @(posedge clk) mask <= mask_nxt;

   // R5
   mask_load_chk: assert property (@(posedge clk) disable iff (rst)
      load |=> mask == $past(load_val));
endmodule

// File: rtl/irq_enable_ctl.sv
module irq_enable_ctl (
   input  logic clk,
   input  logic rst,
   input  logic take,
   input  logic ret,
   input  logic sw_wr,
   input  logic sw_val,
   output logic en,
   output logic en_nxt
);
   logic shadow_q;
   logic shadow_nxt;

   // Priority: entry, then return, then software write.
   always_comb begin
      en_nxt     = en;
      shadow_nxt = shadow_q;
      if (rst) begin
         en_nxt     = 1'b0;
         shadow_nxt = 1'b0;
      end else if (take) begin
         en_nxt     = 1'b0;
         shadow_nxt = en;
      end else if (ret) begin
         en_nxt     = shadow_q;
      end else if (sw_wr) begin
         en_nxt     = sw_val;
      end
   end

   always_ff @(posedge clk) begin
      en       <= en_nxt;
      shadow_q <= shadow_nxt;
   end

   // R7
   take_clears_chk: assert property (@(posedge clk) disable iff (rst)
      take |=> !en);

   // R8
   return_restores_chk: assert property (@(posedge clk) disable iff (rst)
      (ret && !take) |=> en == $past(shadow_q));
endmodule

// File: rtl/lvl_irq_ctrl.sv
module lvl_irq_ctrl
   import lvl_irq_pkg::*;
#(
   parameter int NUM_SRC = 32,
   parameter int DATA_W  = 32
) (
   input  logic               clk,
   input  logic               rst,
   input  logic [NUM_SRC-1:0] irq_lines,
   input  logic               exc_take,
   input  logic               exc_return,
   input  logic               reg_wr,
   input  logic [1:0]         reg_addr,
   input  logic [DATA_W-1:0]  reg_wdata,
   output logic [DATA_W-1:0]  reg_rdata,
   output logic               exc_req
);
   localparam int PAD_W = DATA_W - NUM_SRC;

   if (NUM_SRC < 1 || NUM_SRC > DATA_W) begin : g_bad_width
      $error("lvl_irq_ctrl: NUM_SRC must be within 1..DATA_W");
   end

   logic [NUM_SRC-1:0] status, status_nxt;
   logic [NUM_SRC-1:0] mask, mask_nxt;
   logic               en, en_nxt;
   logic               wr_mask, wr_en;

   assign wr_mask = reg_wr && (irq_reg_e'(reg_addr) == REG_MASK);
   assign wr_en   = reg_wr && (irq_reg_e'(reg_addr) == REG_ENABLE);

   irq_level_track #(.NUM_SRC(NUM_SRC)) u_track (
      .clk(clk), .rst(rst), .lines(irq_lines),
      .status(status), .status_nxt(status_nxt));

   irq_mask_bank #(.NUM_SRC(NUM_SRC)) u_mask (
      .clk(clk), .rst(rst), .load(wr_mask), .load_val(reg_wdata[NUM_SRC-1:0]),
      .mask(mask), .mask_nxt(mask_nxt));

   irq_enable_ctl u_en (
      .clk(clk), .rst(rst), .take(exc_take), .ret(exc_return),
      .sw_wr(wr_en), .sw_val(reg_wdata[0]), .en(en), .en_nxt(en_nxt));

   // Request is computed from the post-edge state so it lines up with the registers.
   always_ff @(posedge clk) begin
      if (rst) exc_req <= 1'b0;
      else     exc_req <= (|(status_nxt & mask_nxt)) & en_nxt;
   end

   logic [DATA_W-1:0] status_ext, mask_ext;
   if (PAD_W > 0) begin : g_pad
      assign status_ext = {{PAD_W{1'b0}}, status};
      assign mask_ext   = {{PAD_W{1'b0}}, mask};
   end else begin : g_nopad
      assign status_ext = status;
      assign mask_ext   = mask;
   end

   always_comb begin
      reg_rdata = '0;
      unique case (irq_reg_e'(reg_addr))
         REG_MASK:   reg_rdata = mask_ext;
         REG_STATUS: reg_rdata = status_ext;
         REG_ENABLE: reg_rdata[0] = en;
         REG_SPARE:  reg_rdata = '0;
      endcase
   end

   // R6
   req_needs_en_chk: assert property (@(posedge clk) disable iff (rst)
      exc_req |-> en);

   // R6
   req_needs_source_chk: assert property (@(posedge clk) disable iff (rst)
      exc_req |-> |(status & mask));

   // R11
   req_when_pending_chk: assert property (@(posedge clk) disable iff (rst)
      (en && |(status & mask)) |-> exc_req);
endmodule

// File: tb/lvl_irq_ctrl_bench.sv
`timescale 1ns/1ps
module lvl_irq_ctrl_bench;
   localparam int N = 32;
   localparam int W = 32;

   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic [N-1:0] irq_lines = '0;
   logic         exc_take = 1'b0, exc_return = 1'b0, reg_wr = 1'b0;
   logic [1:0]   reg_addr = 2'd0;
   logic [W-1:0] reg_wdata = '0;
   logic [W-1:0] reg_rdata;
   logic         exc_req;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   lvl_irq_ctrl #(.NUM_SRC(N), .DATA_W(W)) u_lvl_irq_ctrl (
      .clk(clk), .rst(rst), .irq_lines(irq_lines), .exc_take(exc_take),
      .exc_return(exc_return), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .exc_req(exc_req));

   task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // One cycle from a falling edge to the next falling edge, with the given controls.
   task automatic cyc(input logic wr, input logic [1:0] a, input logic [W-1:0] d,
                      input logic tk, input logic rt);
      reg_wr = wr; reg_addr = a; reg_wdata = d; exc_take = tk; exc_return = rt;
      @(negedge clk);
      reg_wr = 1'b0; exc_take = 1'b0; exc_return = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [W-1:0] v);
      reg_addr = a;
      #0.5;
      v = reg_rdata;
   endtask

   task automatic idle();
      cyc(1'b0, 2'd0, '0, 1'b0, 1'b0);
   endtask

   task automatic t_reset();
      logic [W-1:0] v;
      rd(2'd0, v); check("R1 mask", v, '0);
      rd(2'd1, v); check("R1 status", v, '0);
      rd(2'd2, v); check("R1 enable", v, '0);
      check("R1 req", W'(exc_req), '0);
   endtask

   task automatic t_follow();
      logic [W-1:0] v;
      irq_lines = 32'h0000_0005;
      rd(2'd1, v); check("R2 before edge", v, '0);
      idle();
      rd(2'd1, v); check("R2 set", v, 32'h5);
      irq_lines = '0;
      idle();
      rd(2'd1, v); check("R3 self clear", v, '0);
   endtask

   task automatic t_status_ro();
      logic [W-1:0] v;
      irq_lines = 32'h3;
      idle();
      cyc(1'b1, 2'd1, 32'hFFFF_FFFF, 1'b0, 1'b0);
      rd(2'd1, v); check("R4 status write ignored", v, 32'h3);
      rd(2'd0, v); check("R4 mask untouched", v, '0);
      rd(2'd2, v); check("R4 enable untouched", v, '0);
      irq_lines = '0;
      idle();
   endtask

   task automatic t_mask();
      logic [W-1:0] v;
      cyc(1'b1, 2'd0, 32'hF0, 1'b0, 1'b0);
      rd(2'd0, v); check("R5 mask readback", v, 32'hF0);
      cyc(1'b1, 2'd2, 32'hFFFF_FFFF, 1'b0, 1'b0);
      rd(2'd2, v); check("R9 enable set", v, 32'h1);
      irq_lines = 32'h01;
      idle();
      check("R5 masked source", W'(exc_req), '0);
      irq_lines = 32'h10;
      idle();
      check("R6 request", W'(exc_req), 32'h1);
      irq_lines = '0;
      idle();
      check("R6 request drops", W'(exc_req), '0);
   endtask

   task automatic t_take_return();
      logic [W-1:0] v;
      irq_lines = 32'h20;
      idle();
      check("R6 pending", W'(exc_req), 32'h1);
      cyc(1'b0, 2'd0, '0, 1'b1, 1'b0);
      rd(2'd2, v); check("R7 enable cleared", v, '0);
      check("R7 request blocked", W'(exc_req), '0);
      idle();
      check("R7 still blocked", W'(exc_req), '0);
      cyc(1'b0, 2'd0, '0, 1'b0, 1'b1);
      rd(2'd2, v); check("R8 restored", v, 32'h1);
      check("R11 reasserts", W'(exc_req), 32'h1);
      cyc(1'b1, 2'd2, 32'h0, 1'b0, 1'b0);
      check("R9 sw clear drops req", W'(exc_req), '0);
      cyc(1'b0, 2'd0, '0, 1'b1, 1'b0);
      cyc(1'b0, 2'd0, '0, 1'b0, 1'b1);
      rd(2'd2, v); check("R8 shadow of zero", v, '0);
      irq_lines = '0;
      idle();
   endtask

   task automatic t_priority();
      logic [W-1:0] v;
      cyc(1'b1, 2'd2, 32'h1, 1'b0, 1'b0);
      cyc(1'b0, 2'd0, '0, 1'b1, 1'b1);
      rd(2'd2, v); check("R10 take over return", v, '0);
      cyc(1'b1, 2'd2, 32'h0, 1'b0, 1'b1);
      rd(2'd2, v); check("R10 return over write", v, 32'h1);
      cyc(1'b1, 2'd2, 32'h1, 1'b1, 1'b0);
      rd(2'd2, v); check("R10 take over write", v, '0);
   endtask

   task automatic t_spare();
      logic [W-1:0] v;
      cyc(1'b1, 2'd3, 32'hFFFF_FFFF, 1'b0, 1'b0);
      rd(2'd3, v); check("R12 spare reads zero", v, '0);
      rd(2'd0, v); check("R12 mask unchanged", v, 32'hF0);
      rd(2'd2, v); check("R12 enable unchanged", v, '0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst = 1'b0;
      t_reset();
      t_follow();
      t_status_ro();
      t_mask();
      t_take_return();
      t_priority();
      t_spare();
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #20000;
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired actual=running expected=done");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule